// File: doc/BRIEF.md
# Brain-float immediate to double-precision expander

This unit turns a 16-bit brain-float (BF16) immediate into the IEEE double-precision bit pattern for the same value, ready to be written into a floating-point register. The immediate comes in as three separate instruction fields. The unit joins them in a fixed order and treats the result as the upper half of a single-precision number whose lower sixteen bits are zero. That value is then widened to double precision.

Every single-precision value fits exactly in double precision, so no rounding takes place. The unit handles signed zeros, normal numbers, subnormals, infinities and NaNs. Subnormals are normalised through a leading-one search. NaNs keep their payload and their quiet bit.

The result is registered once, so each accepted immediate appears one clock later, together with a valid strobe. While no new immediate is offered, the output register keeps its last value.

Top module: `bfloat_widen`

## Requirements
- R1: The immediate is `{immHi, immMid, immLo}` (10, 5 and 1 bits), with immHi most significant. Immediate bit 15 is the sign, bits 14:7 the exponent and bits 6:0 the fraction.
- R2: An immediate whose exponent and fraction are zero gives a zero result with the same sign: 0x0000 gives 0x0000000000000000 and 0x8000 gives 0x8000000000000000.
- R3: A normal immediate (exponent 1 to 254) gives bit 63 equal to the sign, bits 62:52 equal to the exponent plus 896, and bits 51:45 equal to the fraction, with bits 44:0 zero. For example, 0x3F80 gives 0x3FF0000000000000 and 0xBFC0 gives 0xBFF8000000000000.
- R4: An exponent of 0xFF with a zero fraction gives a signed infinity: 0x7F80 gives 0x7FF0000000000000 and 0xFF80 gives 0xFFF0000000000000.
- R5: An exponent of 0xFF with a nonzero fraction gives exponent 0x7FF with the fraction copied into bits 51:45. This keeps the quiet bit and the payload: 0x7FC0 gives 0x7FF8000000000000.
- R6: A subnormal immediate (exponent 0, nonzero fraction) is normalised exactly. Let k be one more than the number of leading zeros in the fraction. The result exponent is 897 − k, and the fraction bits below the leading one, shifted left by k, fill bits 51:45. For example, 0x0001 gives 0x37A0000000000000.
- R7: outValid is high in the cycle after each cycle in which inValid is high, and low otherwise. outBits holds that immediate's result while outValid is high.
- R8: While inValid is low, outBits keeps its previous value.
- R9: During and after reset, before any immediate is accepted, outValid is 0 and outBits is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Immediate fields are valid this cycle |
| immHi | input | 10 | Most significant immediate field |
| immMid | input | 5 | Middle immediate field |
| immLo | input | 1 | Least significant immediate field |
| outValid | output | 1 | outBits carries a fresh result |
| outBits | output | 64 | Double-precision result pattern |

## Verification
The bench sweeps all 65,536 immediates and compares each result with a reference value built in floating-point arithmetic, so every exponent and fraction combination is covered. The subnormal corner cases matter most. A wrong leading-zero count or an off-by-one exponent base would shift a value by a power of two, for example 0x0001 or 0x0040. Dropping the implied-bit removal would leave a stray one in the fraction. NaNs with a payload but a clear quiet bit catch a design that forces the quiet bit or clears the payload. Gaps between immediates catch an output that changes or a valid strobe that stays high while nothing is offered.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
  // Default format geometry
  parameter int SRC_EXP_W = 8;
  parameter int SRC_MAN_W = 7;
  parameter int DST_EXP_W = 11;
  parameter int DST_MAN_W = 52;

  // Control strobes handed to the datapath
  typedef struct packed {
    logic capture;
  } strobe_t;
endpackage

// File: rtl/bfw_lzc.sv
module bfw_lzc #(
  parameter int W = 7,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  // Scan upward so the highest set bit writes last and wins
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bfw_ctrl.sv
module bfw_ctrl (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output bfw_pkg::strobe_t strobes,
  output logic             outValid
);
  always_comb begin
    strobes.capture = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/bfw_dpath.sv
module bfw_dpath #(
  parameter int SE = bfw_pkg::SRC_EXP_W,
  parameter int SM = bfw_pkg::SRC_MAN_W,
  parameter int DE = bfw_pkg::DST_EXP_W,
  parameter int DM = bfw_pkg::DST_MAN_W,
  localparam int IMM_W = 1 + SE + SM,
  localparam int RES_W = 1 + DE + DM
) (
  input  logic             clk,
  input  logic             rstN,
  input  bfw_pkg::strobe_t strobes,
  input  logic [IMM_W-1:0] imm,
  output logic [RES_W-1:0] resBits
);
  localparam int LZW       = $clog2(SM + 1);
  localparam int BIAS_SRC  = (1 << (SE - 1)) - 1;
  localparam int BIAS_DST  = (1 << (DE - 1)) - 1;
  localparam int EXP_SHIFT = BIAS_DST - BIAS_SRC;
  localparam int FILL_W    = DM - SM;
  localparam logic [DE-1:0] SUB_BASE = DE'(EXP_SHIFT + 1);

  logic          sgn;
  logic [SE-1:0] eIn;
  logic [SM-1:0] mIn;
  assign {sgn, eIn, mIn} = imm;

  logic [LZW-1:0] lzCnt;
  logic [LZW-1:0] shiftAmt;
  logic [SM-1:0]  normMan;

  bfw_lzc #(.W(SM)) i_lzc (
    .vec   (mIn),
    .zeros (lzCnt)
  );

  // The leading one is shifted out of the field; that bit becomes implicit
  assign shiftAmt = lzCnt + LZW'(1);
  assign normMan  = mIn << shiftAmt;

  logic [DE-1:0] eNext;
  logic [DM-1:0] mNext;

  always_comb begin
    if (eIn == '1) begin
      eNext = '1;
      mNext = {mIn, {FILL_W{1'b0}}};
    end else if (eIn == '0) begin
      if (mIn == '0) begin
        eNext = '0;
        mNext = '0;
      end else begin
        eNext = SUB_BASE - DE'(shiftAmt);
        mNext = {normMan, {FILL_W{1'b0}}};
      end
    end else begin
      eNext = DE'(eIn) + DE'(EXP_SHIFT);
      mNext = {mIn, {FILL_W{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                resBits <= '0;
    else if (strobes.capture) resBits <= {sgn, eNext, mNext};
  end

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(resBits));
  // R3
  sign_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> resBits[RES_W-1] == $past(sgn));
  // R2
  zero_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && eIn == '0 && mIn == '0) |=> resBits[RES_W-2:0] == '0);
  // R4
  special_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && eIn == '1) |=> resBits[RES_W-2 -: DE] == '1);
  // R6
  subnormal_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && eIn == '0 && mIn != '0)
      |=> (resBits[RES_W-2 -: DE] < SUB_BASE) && (resBits[RES_W-2 -: DE] != '0));
endmodule

// File: rtl/bfloat_widen.sv
module bfloat_widen #(
  parameter int HI_W  = 10,
  parameter int MID_W = 5,
  parameter int LO_W  = 1,
  parameter int SE    = bfw_pkg::SRC_EXP_W,
  parameter int SM    = bfw_pkg::SRC_MAN_W,
  parameter int DE    = bfw_pkg::DST_EXP_W,
  parameter int DM    = bfw_pkg::DST_MAN_W,
  localparam int IMM_W = HI_W + MID_W + LO_W,
  localparam int RES_W = 1 + DE + DM
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [HI_W-1:0]  immHi,
  input  logic [MID_W-1:0] immMid,
  input  logic [LO_W-1:0]  immLo,
  output logic             outValid,
  output logic [RES_W-1:0] outBits
);
  bfw_pkg::strobe_t strobes;
  logic [IMM_W-1:0] immJoined;

  // R1: field order fixes the bit weight of each piece
  assign immJoined = {immHi, immMid, immLo};

  bfw_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  bfw_dpath #(.SE(SE), .SM(SM), .DE(DE), .DM(DM)) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .imm     (immJoined),
    .resBits (outBits)
  );
endmodule

// File: tb/test_bfloat_widen.sv
`timescale 1ns/1ps
module test_bfloat_widen;
  typedef struct {
    logic [63:0] bits;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [9:0]  immHi = '0;
  logic [4:0]  immMid = '0;
  logic [0:0]  immLo = '0;
  logic        outValid;
  logic [63:0] outBits;

  int    nRun = 0;
  int    nFail = 0;
  bit    done = 1'b0;
  item_t expQ[$];
  logic [63:0] lastBits = '0;

  always #5 clk = ~clk;

  bfloat_widen i_bfloat_widen (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .immHi(immHi), .immMid(immMid), .immLo(immLo),
    .outValid(outValid), .outBits(outBits)
  );

  // Reference from real arithmetic; specials built from the R4/R5 rules
  function automatic logic [63:0] refBits(logic [15:0] h);
    real v;
    int  e;
    e = int'(h[14:7]);
    if (e == 255) return {h[15], 11'h7FF, h[6:0], 45'b0};
    if (e == 0) v = (real'(h[6:0]) / 128.0) * (2.0 ** (-126.0));
    else        v = (1.0 + real'(h[6:0]) / 128.0) * (2.0 ** real'(e - 127));
    if (h[15]) v = -v;
    return $realtobits(v);
  endfunction

  function automatic string tagFor(logic [15:0] h);
    if (h[14:7] == 8'hFF) return (h[6:0] == 0) ? "R4" : "R5";
    if (h[14:7] == 8'h00) return (h[6:0] == 0) ? "R2" : "R6";
    return "R3";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendRaw(logic [9:0] a, logic [4:0] b, logic c, logic [63:0] exp, string tag);
    @(negedge clk);
    immHi = a; immMid = b; immLo = c; inValid = 1'b1;
    expQ.push_back('{bits: exp, tag: tag});
  endtask

  task automatic send(logic [15:0] h, logic [63:0] exp, string tag);
    sendRaw(h[15:6], h[5:1], h[0], exp, tag);
  endtask

  task automatic idle(int n, logic [15:0] junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      {immHi, immMid, immLo} = junk;
    end
  endtask

  // Monitor: pops one expected item per valid result
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          nRun++; nFail++;
          $display("FAIL R7: got outValid 1 expected 0 (no pending item)");
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(it.tag, outBits, it.bits);
          lastBits = it.bits;
        end
      end else begin
        // R8: held value while idle
        check("R8", outBits, lastBits);
      end
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", {63'b0, outValid}, 64'd0);
    check("R9", outBits, 64'd0);
    rstN = 1'b1;
    idle(3, 16'h3F80);

    // Directed points
    send(16'h0000, 64'h0000000000000000, "R2");
    send(16'h8000, 64'h8000000000000000, "R2");
    send(16'h3F80, 64'h3FF0000000000000, "R3");
    send(16'hBFC0, 64'hBFF8000000000000, "R3");
    send(16'h3FFF, 64'h3FFFE00000000000, "R3");
    send(16'h0080, 64'h3810000000000000, "R3");
    send(16'h7F7F, 64'h47EFE00000000000, "R3");
    send(16'h7F80, 64'h7FF0000000000000, "R4");
    send(16'hFF80, 64'hFFF0000000000000, "R4");
    send(16'h7FC0, 64'h7FF8000000000000, "R5");
    send(16'h7F81, 64'h7FF0200000000000, "R5");
    send(16'h0001, 64'h37A0000000000000, "R6");
    send(16'h0040, 64'h3800000000000000, "R6");
    send(16'h0041, 64'h3800400000000000, "R6");
    idle(4, 16'hFFFF);
    // R1: field order, each field alone
    sendRaw(10'h200, 5'h00, 1'b0, refBits(16'h8000), "R1");
    sendRaw(10'h000, 5'h10, 1'b0, refBits(16'h0020), "R1");
    sendRaw(10'h000, 5'h00, 1'b1, refBits(16'h0001), "R1");
    sendRaw(10'h0FE, 5'h00, 1'b0, refBits(16'h3F80), "R1");
    idle(5, 16'h1234);

    // Full sweep, with a gap every 4096 values
    for (int h = 0; h < 65536; h++) begin
      send(16'(h), refBits(16'(h)), tagFor(16'(h)));
      if ((h % 4096) == 4095) idle(2, 16'(h ^ 16'h5A5A));
    end
    idle(4, 16'h0000);

    // R7: nothing left outstanding
    check("R7", 64'(expQ.size()), 64'd0);
    check("R7", {63'b0, outValid}, 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule